// File: doc/BRIEF.md
# SAR ADC Conversion and Readout Sequencer

This block runs a successive-approximation converter through its conversion-start line and a serial read port. Each cycle is started by a built-in periodic timer or by a single-shot request. The block holds the start line low for a quiet interval. It then raises the start line with the pulse width and conversion wait that the chosen wiring needs. After that it clocks the result in with a serial clock that idles low and captures one bit on each rising edge, most significant bit first. Every result leaves as a 32-bit word with a one-cycle valid strobe and a device index.

Four wiring modes are supported:
- a separate start line with its own active-low chip select;
- the start line tied to chip select, with the result read after the conversion;
- the same tied wiring in streaming form, where a short start pulse is followed at once by reading the previous result during the new conversion;
- a daisy chain with an active-high select, where the words of all chained devices are read in one burst.

Result width is 14, 16 or 18 bits. 18-bit results are sign-extended and narrower results are zero-filled. All intervals come from nanosecond parameters rounded up to whole clock cycles. The configuration is sampled only while the sequencer is idle. A start request that arrives during a cycle is dropped and sets a sticky overrun flag.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, `cnv_o` is 0, `cs_o` is 1, `sclk_o` is 0, and `busy_o`, `smp_vld_o` and `overrun_o` are all 0.
- R2: Mode code 0 (separate select). `cnv_o` is low for 2 cycles after the start, then high for the conversion time plus the read. `cs_o` stays high through the quiet time and the whole conversion time, then falls for 2·W cycles while W bits are read.
- R3: Mode code 1 (tied). The shared line (`cnv_o` = `cs_o`) idles high. It goes low for 2 cycles, high for the conversion time, low for 2·W cycles of read, and then returns high.
- R4: Mode code 2 (streaming). The shared line goes low for 2 cycles, high for exactly 1 cycle, then low for 2·W cycles while the previous result is read.
- R5: Mode code 3 (chain). The shared line idles low and is active high. It is low for 2 cycles, then high for the normal conversion time plus 2·W·N cycles. N words are emitted with `smp_idx_o` counting 0..N-1 in read order.
- R6: `sclk_o` is low whenever the block is idle. Each cycle gives exactly W·N rising edges. Each bit is taken from `sdi_i` at a rising edge, first bit as the word MSB.
- R7: Width code 0 gives 14 bits and code 1 gives 16 bits, both zero-filled to 32. Code 2 gives 18 bits, sign-extended from bit 17.
- R8: With a 10 ns clock, the conversion time is 42 cycles for 14/16-bit and 50 cycles for 18-bit. With `turbo_i` set it is 32 or 40 cycles, except in chain mode, where turbo is ignored.
- R9: While `run_i` is high, a cycle starts every `period_i` clock cycles.
- R10: A start request while `busy_o` is high starts nothing, and `overrun_o` becomes 1 and stays 1 until reset.
- R11: Changes to mode or width during a cycle do not affect that cycle.
- R12: In chain mode a chain length of 0 is read as 1 device, and lengths above 32 are read as 32 devices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Wiring mode code (0 separate, 1 tied, 2 streaming, 3 chain) |
| wsel_i | input | 2 | Width code (0: 14, 1: 16, 2: 18 bits) |
| turbo_i | input | 1 | Select the short conversion time |
| chain_n_i | input | 6 | Number of chained devices |
| run_i | input | 1 | Enable the periodic timer |
| period_i | input | 16 | Timer period in clock cycles |
| shot_i | input | 1 | Single-shot start request |
| sdi_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Conversion-start line |
| cs_o | output | 1 | Chip-select line level |
| sclk_o | output | 1 | Serial clock |
| busy_o | output | 1 | A cycle is in progress |
| smp_o | output | 32 | Formatted result word |
| smp_vld_o | output | 1 | Result word valid for one cycle |
| smp_idx_o | output | 5 | Device index of the result word |
| overrun_o | output | 1 | Sticky dropped-trigger flag |

## Verification
The assertions assume that the width code and chain length are legal encodings. They also assume that the serial data input changes only on the falling edges of the serial clock, so that the word formatting seen at the output is a property of the design alone. The stimulus drives the serial input from a shift model clocked by the design's own falling clock edge. Configuration is changed only between cycles, except in the one directed test that checks it is ignored. Timer periods are kept well above the longest cycle, except in the single overrun test.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  localparam int MAXW = 18;

  typedef enum logic [1:0] {
    WIRE_SEP    = 2'd0,
    WIRE_TIED   = 2'd1,
    WIRE_STREAM = 2'd2,
    WIRE_CHAIN  = 2'd3
  } wiring_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_QUIET = 3'd1,
    ST_PULSE = 3'd2,
    ST_CONV  = 3'd3,
    ST_SHIFT = 3'd4
  } seq_state_e;

  // Round a nanosecond interval up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(int ns, int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic [4:0] width_of(logic [1:0] wsel);
    case (wsel)
      2'd0:    return 5'd14;
      2'd1:    return 5'd16;
      default: return 5'd18;
    endcase
  endfunction

  function automatic logic [31:0] format_word(logic [MAXW-1:0] raw, logic [1:0] wsel);
    case (wsel)
      2'd0:    return {18'd0, raw[13:0]};
      2'd1:    return {16'd0, raw[15:0]};
      default: return {{14{raw[17]}}, raw};
    endcase
  endfunction

  // Line levels {cnv, cs} for a given state under a given wiring.
  function automatic logic [1:0] line_levels(seq_state_e st, wiring_e m);
    logic act;
    case (m)
      WIRE_SEP: begin
        act = (st == ST_CONV) || (st == ST_SHIFT);
        return {act, (st != ST_SHIFT)};
      end
      WIRE_CHAIN: begin
        act = (st == ST_CONV) || (st == ST_SHIFT);
        return {act, act};
      end
      default: begin
        act = !((st == ST_QUIET) || (st == ST_SHIFT));
        return {act, act};
      end
    endcase
  endfunction

endpackage

// File: rtl/sar_rate_timer.sv
module sar_rate_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);

  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-1:0] last;

  assign last = (period_i == '0) ? '0 : period_i - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (!run_i) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt >= last) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_o <= 1'b0;
    end
  end

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_seq_pkg::*;
#(
  parameter int CLK_NS          = 10,
  parameter int QUIET_NS        = 20,
  parameter int CNVH_NS         = 10,
  parameter int CONV_NS         = 420,
  parameter int CONV_TURBO_NS   = 320,
  parameter int CONV18_NS       = 500,
  parameter int CONV18_TURBO_NS = 400,
  parameter int MAX_CHAIN       = 32,
  parameter int CHAIN_W         = $clog2(MAX_CHAIN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic [1:0]         wsel_i,
  input  logic               turbo_i,
  input  logic [CHAIN_W-1:0] chain_n_i,
  input  logic               sdi_i,
  output logic               cnv_o,
  output logic               cs_o,
  output logic               sclk_o,
  output logic               busy_o,
  output logic               overrun_o,
  output logic               idle_o,
  output logic               bit_vld_o,
  output logic               bit_o,
  output logic [1:0]         wsel_q_o
);

  localparam int C_QUIET  = ns_to_cyc(QUIET_NS, CLK_NS);
  localparam int C_CNVH   = ns_to_cyc(CNVH_NS, CLK_NS);
  localparam int C_CN     = ns_to_cyc(CONV_NS, CLK_NS);
  localparam int C_CT     = ns_to_cyc(CONV_TURBO_NS, CLK_NS);
  localparam int C_18N    = ns_to_cyc(CONV18_NS, CLK_NS);
  localparam int C_18T    = ns_to_cyc(CONV18_TURBO_NS, CLK_NS);
  localparam int CNT_W    = $clog2(C_QUIET + C_CNVH + C_CN + C_18N + 2);
  localparam int TOT_W    = $clog2(MAXW * MAX_CHAIN + 1);

  seq_state_e          state, state_n;
  wiring_e             mode_q, mode_n;
  logic [1:0]          wsel_q;
  logic                turbo_q;
  logic [CHAIN_W-1:0]  n_q, n_eff;
  logic [CNT_W-1:0]    cnt, cnt_n, conv_len;
  logic                ph, ph_n;
  logic [TOT_W-1:0]    bits, bits_n, total;
  logic                ovr_n;
  logic                use_turbo;

  assign mode_n    = (state == ST_IDLE) ? wiring_e'(mode_i) : mode_q;
  assign use_turbo = turbo_q && (mode_q != WIRE_CHAIN);

  always_comb begin
    if (mode_q != WIRE_CHAIN)               n_eff = CHAIN_W'(1);
    else if (n_q == '0)                     n_eff = CHAIN_W'(1);
    else if (n_q > CHAIN_W'(MAX_CHAIN))     n_eff = CHAIN_W'(MAX_CHAIN);
    else                                    n_eff = n_q;
  end

  assign total = TOT_W'(width_of(wsel_q)) * TOT_W'(n_eff);

  always_comb begin
    if (wsel_q[1]) conv_len = use_turbo ? CNT_W'(C_18T) : CNT_W'(C_18N);
    else           conv_len = use_turbo ? CNT_W'(C_CT)  : CNT_W'(C_CN);
  end

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    ph_n    = ph;
    bits_n  = bits;
    ovr_n   = overrun_o | (start_i && (state != ST_IDLE));
    case (state)
      ST_IDLE: begin
        if (start_i) begin
          state_n = ST_QUIET;
          cnt_n   = CNT_W'(C_QUIET - 1);
        end
      end
      ST_QUIET: begin
        if (cnt != '0) begin
          cnt_n = cnt - 1'b1;
        end else if (mode_q == WIRE_STREAM) begin
          state_n = ST_PULSE;
          cnt_n   = CNT_W'(C_CNVH - 1);
        end else begin
          state_n = ST_CONV;
          cnt_n   = conv_len - 1'b1;
        end
      end
      ST_PULSE, ST_CONV: begin
        if (cnt != '0) begin
          cnt_n = cnt - 1'b1;
        end else begin
          state_n = ST_SHIFT;
          ph_n    = 1'b0;
          bits_n  = '0;
        end
      end
      ST_SHIFT: begin
        if (!ph) begin
          ph_n   = 1'b1;
          bits_n = bits + 1'b1;
        end else begin
          ph_n = 1'b0;
          if (bits == total) state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_q    <= WIRE_SEP;
      wsel_q    <= 2'd0;
      turbo_q   <= 1'b0;
      n_q       <= '0;
      cnt       <= '0;
      ph        <= 1'b0;
      bits      <= '0;
      overrun_o <= 1'b0;
      cnv_o     <= 1'b0;
      cs_o      <= 1'b1;
      sclk_o    <= 1'b0;
      busy_o    <= 1'b0;
    end else begin
      state     <= state_n;
      cnt       <= cnt_n;
      ph        <= ph_n;
      bits      <= bits_n;
      overrun_o <= ovr_n;
      if (state == ST_IDLE) begin
        mode_q  <= wiring_e'(mode_i);
        wsel_q  <= wsel_i;
        turbo_q <= turbo_i;
        n_q     <= chain_n_i;
      end
      {cnv_o, cs_o} <= line_levels(state_n, mode_n);
      sclk_o        <= (state_n == ST_SHIFT) && ph_n;
      busy_o        <= (state_n != ST_IDLE);
    end
  end

  assign idle_o    = (state == ST_IDLE);
  assign bit_vld_o = (state == ST_SHIFT) && !ph;
  assign bit_o     = sdi_i;
  assign wsel_q_o  = wsel_q;

endmodule

// File: rtl/sar_word_deser.sv
module sar_word_deser
  import sar_seq_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  input  logic [1:0]       wsel_i,
  output logic [31:0]      smp_o,
  output logic             smp_vld_o,
  output logic [IDX_W-1:0] smp_idx_o
);

  logic [MAXW-1:0]  sr, sr_n;
  logic [4:0]       wcnt;
  logic [IDX_W-1:0] idx;

  assign sr_n = {sr[MAXW-2:0], bit_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr        <= '0;
      wcnt      <= '0;
      idx       <= '0;
      smp_o     <= '0;
      smp_vld_o <= 1'b0;
      smp_idx_o <= '0;
    end else begin
      smp_vld_o <= 1'b0;
      if (idle_i) begin
        wcnt <= '0;
        idx  <= '0;
      end else if (bit_vld_i) begin
        sr <= sr_n;
        if (wcnt == width_of(wsel_i) - 5'd1) begin
          wcnt      <= '0;
          smp_o     <= format_word(sr_n, wsel_i);
          smp_vld_o <= 1'b1;
          smp_idx_o <= idx;
          idx       <= idx + 1'b1;
        end else begin
          wcnt <= wcnt + 5'd1;
        end
      end
    end
  end

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_seq_pkg::*;
#(
  parameter int CLK_NS          = 10,
  parameter int QUIET_NS        = 20,
  parameter int CNVH_NS         = 10,
  parameter int CONV_NS         = 420,
  parameter int CONV_TURBO_NS   = 320,
  parameter int CONV18_NS       = 500,
  parameter int CONV18_TURBO_NS = 400,
  parameter int MAX_CHAIN       = 32,
  parameter int PERIOD_W        = 16,
  parameter int CHAIN_W         = $clog2(MAX_CHAIN + 1),
  parameter int IDX_W           = (MAX_CHAIN > 1) ? $clog2(MAX_CHAIN) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode_i,
  input  logic [1:0]          wsel_i,
  input  logic                turbo_i,
  input  logic [CHAIN_W-1:0]  chain_n_i,
  input  logic                run_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                shot_i,
  input  logic                sdi_i,
  output logic                cnv_o,
  output logic                cs_o,
  output logic                sclk_o,
  output logic                busy_o,
  output logic [31:0]         smp_o,
  output logic                smp_vld_o,
  output logic [IDX_W-1:0]    smp_idx_o,
  output logic                overrun_o
);

  logic       tick;
  logic       idle;
  logic       bit_vld;
  logic       bit_val;
  logic [1:0] wsel_q;

  sar_rate_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run_i    (run_i),
    .period_i (period_i),
    .tick_o   (tick)
  );

  sar_seq_fsm #(
    .CLK_NS          (CLK_NS),
    .QUIET_NS        (QUIET_NS),
    .CNVH_NS         (CNVH_NS),
    .CONV_NS         (CONV_NS),
    .CONV_TURBO_NS   (CONV_TURBO_NS),
    .CONV18_NS       (CONV18_NS),
    .CONV18_TURBO_NS (CONV18_TURBO_NS),
    .MAX_CHAIN       (MAX_CHAIN),
    .CHAIN_W         (CHAIN_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start_i   (shot_i | tick),
    .mode_i    (mode_i),
    .wsel_i    (wsel_i),
    .turbo_i   (turbo_i),
    .chain_n_i (chain_n_i),
    .sdi_i     (sdi_i),
    .cnv_o     (cnv_o),
    .cs_o      (cs_o),
    .sclk_o    (sclk_o),
    .busy_o    (busy_o),
    .overrun_o (overrun_o),
    .idle_o    (idle),
    .bit_vld_o (bit_vld),
    .bit_o     (bit_val),
    .wsel_q_o  (wsel_q)
  );

  sar_word_deser #(.IDX_W(IDX_W)) u_deser (
    .clk       (clk),
    .rst       (rst),
    .idle_i    (idle),
    .bit_vld_i (bit_vld),
    .bit_i     (bit_val),
    .wsel_i    (wsel_q),
    .smp_o     (smp_o),
    .smp_vld_o (smp_vld_o),
    .smp_idx_o (smp_idx_o)
  );

endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        sclk_o,
  input logic        busy_o,
  input logic [31:0] smp_o,
  input logic        smp_vld_o,
  input logic        overrun_o
);

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !sclk_o); // R6

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    smp_vld_o |=> !smp_vld_o); // R5

  AST_VLD_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    smp_vld_o |-> busy_o); // R6

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o); // R10

  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
    (smp_vld_o && (smp_o[31:18] != 14'd0)) |-> (smp_o[31:17] == 15'h7FFF)); // R7

endmodule

bind sar_adc_seq sar_adc_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sclk_o    (sclk_o),
  .busy_o    (busy_o),
  .smp_o     (smp_o),
  .smp_vld_o (smp_vld_o),
  .overrun_o (overrun_o)
);

// File: tb/tb_sar_adc_seq.sv
module tb_sar_adc_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NREC = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic [1:0]  wsel = 2'd0;
  logic        turbo = 1'b0;
  logic [5:0]  chain_n = 6'd1;
  logic        run = 1'b0;
  logic [15:0] period = 16'd0;
  logic        shot = 1'b0;
  logic        sdi;
  logic        cnv_o, cs_o, sclk_o, busy_o, smp_vld_o, overrun_o;
  logic [31:0] smp_o;
  logic [4:0]  smp_idx_o;

  logic [575:0] mdata = '0;
  logic         mrst = 1'b0;
  int           mpos;

  logic         rc [NREC];
  logic         rs [NREC];
  logic         rk [NREC];
  int           nrec;
  logic [31:0]  wv [NREC];
  int           wi [NREC];
  int           vcnt = 0;
  int           n_chk = 0;
  int           n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_adc_seq dut (
    .clk(clk), .rst(rst), .mode_i(mode), .wsel_i(wsel), .turbo_i(turbo),
    .chain_n_i(chain_n), .run_i(run), .period_i(period), .shot_i(shot),
    .sdi_i(sdi), .cnv_o(cnv_o), .cs_o(cs_o), .sclk_o(sclk_o), .busy_o(busy_o),
    .smp_o(smp_o), .smp_vld_o(smp_vld_o), .smp_idx_o(smp_idx_o), .overrun_o(overrun_o)
  );

  // Converter model: next bit appears after each falling serial clock edge.
  always @(negedge sclk_o or posedge mrst)
    if (mrst) mpos <= 0;
    else      mpos <= mpos + 1;

  assign sdi = (mpos < 576) ? mdata[575 - mpos] : 1'b0;

  always @(negedge clk)
    if (!rst && smp_vld_o) begin
      wv[vcnt % NREC] = smp_o;
      wi[vcnt % NREC] = int'(smp_idx_o);
      vcnt++;
    end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wid(int w);
    return (w == 0) ? 14 : (w == 1) ? 16 : 18;
  endfunction

  function automatic int conv_cyc(int w, int t, int m);
    bit tb = (t != 0) && (m != 3);
    if (w >= 2) return tb ? 40 : 50;
    return tb ? 32 : 42;
  endfunction

  function automatic int n_words(int m, int n);
    if (m != 3) return 1;
    if (n == 0) return 1;
    return (n > 32) ? 32 : n;
  endfunction

  function automatic logic [31:0] exp_word(logic [575:0] d, int w, int i);
    int          bw = wid(w);
    logic [575:0] s;
    logic [17:0]  r;
    s = d << (i * bw);
    r = s[575:558];
    r = r >> (18 - bw);
    if (bw == 18) return {{14{r[17]}}, r};
    return {14'd0, r};
  endfunction

  function automatic int runlen(int sel, int start);
    int  i = start;
    logic v = (sel == 0) ? rc[start] : rs[start];
    while (i < nrec && ((sel == 0) ? rc[i] : rs[i]) == v) i++;
    return i - start;
  endfunction

  task automatic frame(input int m, input int w, input int t, input int n,
                       input logic [575:0] d, input bit chg);
    int bw, nw, cc, vb, rises;
    bit ok;
    @(negedge clk);
    mode = 2'(m); wsel = 2'(w); turbo = 1'(t); chain_n = 6'(n);
    mdata = d; mrst = 1'b1; #1; mrst = 1'b0;
    @(negedge clk);
    vb = vcnt;
    shot = 1'b1;
    @(negedge clk);
    shot = 1'b0;
    nrec = 0;
    forever begin
      rc[nrec] = cnv_o; rs[nrec] = cs_o; rk[nrec] = sclk_o;
      nrec++;
      if (!busy_o || nrec >= NREC) break;
      if (chg && nrec == 5) begin mode = 2'd3; wsel = 2'd2; end
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    bw = wid(w); nw = n_words(m, n); cc = conv_cyc(w, t, m);
    case (m)
      0: begin
        ok = rc[0] == 0 && runlen(0, 0) == 2 && rc[2] == 1 && runlen(0, 2) == cc + 2*bw &&
             rs[0] == 1 && runlen(1, 0) == 2 + cc && rs[2+cc] == 0 && runlen(1, 2 + cc) == 2*bw;
        chk(ok, "R2 R8 separate-select timing", runlen(1, 0), 2 + cc);
      end
      1: begin
        ok = rc[0] == 0 && runlen(0, 0) == 2 && runlen(0, 2) == cc && rc[2+cc] == 0 &&
             runlen(0, 2 + cc) == 2*bw && rc[nrec-1] == 1 && rs[2] == 1;
        chk(ok, "R3 R8 tied timing", runlen(0, 2), cc);
      end
      2: begin
        ok = rc[0] == 0 && runlen(0, 0) == 2 && rc[2] == 1 && runlen(0, 2) == 1 &&
             runlen(0, 3) == 2*bw && rs[2] == 1;
        chk(ok, "R4 streaming pulse timing", runlen(0, 2), 1);
      end
      default: begin
        ok = rc[0] == 0 && runlen(0, 0) == 2 && rc[2] == 1 && runlen(0, 2) == cc + 2*bw*nw &&
             rs[2] == 1 && rs[0] == 0 && rc[nrec-1] == 0;
        chk(ok, "R5 R8 chain timing", runlen(0, 2), cc + 2*bw*nw);
      end
    endcase
    rises = 0;
    for (int k = 1; k < nrec; k++) if (!rk[k-1] && rk[k]) rises++;
    chk(rises == bw*nw && !rk[nrec-1], "R6 serial clock edges", rises, bw*nw);
    chk(vcnt - vb == nw, "R5 R12 word count", vcnt - vb, nw);
    for (int i = 0; i < nw && i < vcnt - vb; i++) begin
      logic [31:0] e = exp_word(d, w, i);
      logic [31:0] a = wv[(vb + i) % NREC];
      if (a != e || wi[(vb + i) % NREC] != i) begin
        chk(1'b0, "R7 R6 word value/index", longint'(a), longint'(e));
      end else if (i == 0) begin
        chk(1'b1, "R7 word value", 0, 0);
      end
    end
  endtask

  initial begin
    logic [575:0] d;
    int t[4];
    int nt, vb;
    logic pb;
    void'($urandom(32'h5A3C_0017));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cnv_o == 0 && cs_o == 1 && sclk_o == 0 && busy_o == 0 && smp_vld_o == 0 && overrun_o == 0,
        "R1 reset state", {cnv_o, cs_o, sclk_o, busy_o, smp_vld_o, overrun_o}, 6'b010000);

    // Directed: sign and zero fill, turbo, each mode.
    d = '0; d[575] = 1'b1; d[560] = 1'b1;
    frame(0, 2, 0, 1, d, 1'b0);  // R7 negative 18-bit
    frame(0, 1, 0, 1, d, 1'b0);  // R7 16-bit MSB set stays positive
    frame(1, 0, 1, 1, d, 1'b0);  // R8 turbo tied 14-bit
    chk(cnv_o == 1 && cs_o == 1, "R3 tied idle high", cnv_o, 1);
    frame(2, 2, 0, 1, d, 1'b0);  // R4
    frame(3, 0, 1, 3, {$urandom(), $urandom(), 512'd0}, 1'b0);  // R8 turbo ignored in chain
    chk(cnv_o == 0 && cs_o == 0, "R5 chain idle low", cs_o, 0);
    frame(3, 1, 0, 0, {$urandom(), 544'd0}, 1'b0);   // R12 zero length
    for (int k = 0; k < 18; k++) d[k*32 +: 32] = $urandom();
    frame(3, 0, 0, 40, d, 1'b0);  // R12 clamp to 32
    frame(0, 0, 0, 1, d, 1'b1);   // R11 config change mid-cycle ignored

    // Random mix.
    for (int it = 0; it < 40; it++) begin
      int m = int'($urandom() % 4);
      for (int k = 0; k < 18; k++) d[k*32 +: 32] = $urandom();
      frame(m, int'($urandom() % 3), int'($urandom() % 2),
            (m == 3) ? 1 + int'($urandom() % 4) : 1, d, 1'b0);
    end

    // Periodic timer: R9.
    @(negedge clk);
    mode = 2'd0; wsel = 2'd0; turbo = 1'b0; mdata = '0;
    period = 16'd150; run = 1'b1;
    nt = 0; pb = busy_o;
    for (int c = 0; c < 700 && nt < 4; c++) begin
      @(negedge clk);
      if (busy_o && !pb) begin t[nt] = c; nt++; end
      pb = busy_o;
    end
    run = 1'b0;
    chk(nt >= 3 && t[1] - t[0] == 150 && t[2] - t[1] == 150, "R9 periodic start spacing",
        (nt >= 2) ? t[1] - t[0] : 0, 150);
    repeat (200) @(negedge clk);
    chk(overrun_o == 0, "R9 R10 no overrun with slow period", overrun_o, 0);

    // Overrun: R10.
    vb = vcnt;
    shot = 1'b1; @(negedge clk); shot = 1'b0;
    repeat (3) @(negedge clk);
    shot = 1'b1; @(negedge clk); shot = 1'b0;
    while (busy_o) @(negedge clk);
    chk(overrun_o == 1, "R10 overrun set", overrun_o, 1);
    repeat (10) @(negedge clk);
    chk(busy_o == 0 && vcnt - vb == 1, "R10 dropped trigger", vcnt - vb, 1);
    frame(1, 1, 0, 1, d, 1'b0);
    chk(overrun_o == 1, "R10 overrun sticky", overrun_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail + 1);
    $finish;
  end

endmodule